// File: doc/BRIEF.md
# Transfer-Triggered Move Processor Core

This block is a small, non-pipelined processor datapath with exactly one instruction: a move. Each 16-bit word read from code memory names a destination and a source, and those two codes steer the datapath directly. No opcode decoder sits in between. Some destination codes attach a side effect to the move. Several codes point at the same accumulator, and each of them picks its own operation: load, add or subtract.

Code memory is a separate space from the registers. It is reached through a synchronous read port: the core drives the address of the *next* instruction, and the word arrives on the next clock edge. As a result, every instruction completes in one cycle. A jump costs only its own cycle, and the instruction at the target runs on the very next cycle. A jump beyond the current 256-word page needs two instructions: first a prefix byte is loaded, then the program counter is written.

The program counter, the general registers, the accumulators and the carry/zero flags are all visible on output ports so that an enclosing environment can check them.

Top module: `xfer_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0, and the PC, registers, accumulators, flags and prefix clear to 0. The word at address 0 executes in the first cycle after release, so right after release `imem_addr` already shows that word's successor or jump target.
- R2: The instruction word is split into three fields. Bit 15 selects the format, bits 14:8 are the destination code, and bits 7:0 are the source field.
- R3: With format 0, the source byte is zero-extended to 16 bits and written to the destination, provided no prefix is pending.
- R4: With format 1, the source field selects a module and its value is copied to the destination. The source codes are:
  - 0x00+i: register i
  - 0x10+k: accumulator k
  - 0x20: the address of the executing instruction
  - 0x22: the flags, with zero in bit 1 and carry in bit 0
- R5: A format-1 source code that maps to no module reads as 0.
- R6: Destination 0x10+4k+op addresses accumulator k for every such code: op 0 loads it, op 1 adds the moved value to it, and op 2 subtracts the moved value from it. Op 3 is unmapped.
- R7: An add sets carry to the carry-out. A subtract sets carry to the borrow. Both set zero when the 16-bit result is 0. Only add, subtract and a write to destination 0x22 change the flags; that write takes carry from value bit 0 and zero from value bit 1.
- R8: One instruction executes per clock. The PC steps by 1 unless the instruction targets the PC, and `pc_o` always equals the `imem_addr` of the previous cycle.
- R9: Destination 0x20 jumps in one cycle, and the target instruction executes on the next cycle. A format-1 move gives the full target. A format-0 move replaces only PC bits 7:0.
- R10: Destination 0x21 stores a prefix byte. The next instruction consumes it. If that instruction is format 0, its value becomes {prefix, byte}, so prefix followed by PC write forms a two-cycle long jump.
- R11: A destination code that maps to nothing (including 0x13 and 0x30-0x7F) changes no register, accumulator or flag. Only the PC advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PC_W | Address of the next instruction for the synchronous code memory |
| imem_rdata | input | 16 | Instruction word registered by code memory |
| pc_o | output | PC_W | Address of the instruction executing now |
| acc_o | output | NUM_ACC*16 | Accumulators, accumulator k at bits 16k+15:16k |
| reg_o | output | NUM_REG*16 | General registers, register i at bits 16i+15:16i |
| flags_o | output | 2 | Bit 1 zero, bit 0 carry/borrow |

## Verification
The hardest behaviour to provoke is the interaction of the hidden prefix byte with whatever instruction follows it. This includes a long jump that lands in another page, the consumption of the prefix by the next instruction, and a 16-bit immediate built from a prefix and a byte. The prefix is never visible on the ports. The stimulus therefore places prefix-then-write pairs at chosen addresses and observes the results indirectly. It checks that the accumulator received the combined word. It checks that the PC landed at the far page, and that the very next immediate came out zero-extended. It also reads the executing address through the PC source code to confirm that the landing happened in a single cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int DATA_W = 16;
    localparam int DST_W  = 7;
    localparam int SRC_W  = 8;

    typedef struct packed {
        logic             fmt;
        logic [DST_W-1:0] dst;
        logic [SRC_W-1:0] src;
    } instr_t;

    localparam logic [DST_W-1:0] DST_ACC_GRP = 7'h10;
    localparam logic [DST_W-1:0] DST_PC      = 7'h20;
    localparam logic [DST_W-1:0] DST_PFX     = 7'h21;
    localparam logic [DST_W-1:0] DST_STAT    = 7'h22;

    localparam logic [SRC_W-1:0] SRC_ACC_GRP = 8'h10;
    localparam logic [SRC_W-1:0] SRC_PC      = 8'h20;
    localparam logic [SRC_W-1:0] SRC_STAT    = 8'h22;

    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2,
        ACC_NONE = 2'd3
    } acc_op_e;
endpackage

// File: rtl/xfer_dst_dec.sv
module xfer_dst_dec
    import xfer_pkg::*;
#(
    parameter int NUM_REG = 4,
    parameter int NUM_ACC = 2
) (
    input  logic [DST_W-1:0]   dst,
    output logic [NUM_REG-1:0] reg_we,
    output logic [NUM_ACC-1:0] acc_we,
    output acc_op_e            acc_op,
    output logic               pc_we,
    output logic               pfx_we,
    output logic               stat_we
);
    logic acc_grp;

    assign acc_grp = (dst[DST_W-1:4] == DST_ACC_GRP[DST_W-1:4]);
    assign acc_op  = acc_op_e'(dst[1:0]);
    assign pc_we   = (dst == DST_PC);
    assign pfx_we  = (dst == DST_PFX);
    assign stat_we = (dst == DST_STAT);

    for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_reg
        assign reg_we[gi] = (dst == DST_W'(gi));
    end

    for (genvar gk = 0; gk < NUM_ACC; gk++) begin : g_acc
        assign acc_we[gk] = acc_grp && (dst[3:2] == 2'(gk)) && (dst[1:0] != 2'd3);
    end
endmodule

// File: rtl/xfer_src_mux.sv
module xfer_src_mux
    import xfer_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int NUM_REG = 4,
    parameter int NUM_ACC = 2
) (
    input  logic [SRC_W-1:0]                src,
    input  logic [NUM_REG-1:0][DATA_W-1:0]  regs,
    input  logic [NUM_ACC-1:0][DATA_W-1:0]  accs,
    input  logic [PC_W-1:0]                 pc,
    input  logic                            cf,
    input  logic                            zf,
    output logic [DATA_W-1:0]               value
);
    always_comb begin
        value = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (src == SRC_W'(i)) value = regs[i];
        end
        for (int k = 0; k < NUM_ACC; k++) begin
            if (src == SRC_ACC_GRP + SRC_W'(k)) value = accs[k];
        end
        if (src == SRC_PC)   value = DATA_W'(pc);
        if (src == SRC_STAT) value = {{(DATA_W-2){1'b0}}, zf, cf};
    end
endmodule

// File: rtl/xfer_alu.sv
module xfer_alu
    import xfer_pkg::*;
(
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero,
    output logic              arith
);
    logic [DATA_W:0] wide;

    always_comb begin
        wide  = {1'b0, operand};
        arith = 1'b0;
        unique case (op)
            ACC_ADD: begin
                wide  = {1'b0, acc} + {1'b0, operand};
                arith = 1'b1;
            end
            ACC_SUB: begin
                wide  = {1'b0, acc} - {1'b0, operand};
                arith = 1'b1;
            end
            default: wide = {1'b0, operand};
        endcase
        result = wide[DATA_W-1:0];
        carry  = wide[DATA_W];
        zero   = (wide[DATA_W-1:0] == '0);
    end
endmodule

// File: rtl/xfer_core.sv
module xfer_core
    import xfer_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int NUM_REG = 4,
    parameter int NUM_ACC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [PC_W-1:0]           imem_addr,
    input  logic [15:0]               imem_rdata,
    output logic [PC_W-1:0]           pc_o,
    output logic [NUM_ACC*DATA_W-1:0] acc_o,
    output logic [NUM_REG*DATA_W-1:0] reg_o,
    output logic [1:0]                flags_o
);
    localparam int PFX_W = DATA_W - SRC_W;

    typedef struct packed {
        logic [PC_W-1:0]                pc;
        logic [NUM_REG-1:0][DATA_W-1:0] regs;
        logic [NUM_ACC-1:0][DATA_W-1:0] accs;
        logic                           cf;
        logic                           zf;
        logic [PFX_W-1:0]               pfx;
        logic                           pfx_v;
    } state_t;

    state_t st_d, st_q;

    instr_t               ins;
    logic [NUM_REG-1:0]   reg_we;
    logic [NUM_ACC-1:0]   acc_we;
    acc_op_e              acc_op;
    logic                 pc_we, pfx_we, stat_we;
    logic [DATA_W-1:0]    src_val, imm_val, mov_val, acc_cur;
    logic [DATA_W-1:0]    alu_res;
    logic                 alu_c, alu_z, alu_arith;
    logic [PC_W-1:0]      jmp_tgt;

    assign ins = instr_t'(imem_rdata);

    xfer_dst_dec #(.NUM_REG(NUM_REG), .NUM_ACC(NUM_ACC)) u_dec (
        .dst     (ins.dst),
        .reg_we  (reg_we),
        .acc_we  (acc_we),
        .acc_op  (acc_op),
        .pc_we   (pc_we),
        .pfx_we  (pfx_we),
        .stat_we (stat_we)
    );

    xfer_src_mux #(.PC_W(PC_W), .NUM_REG(NUM_REG), .NUM_ACC(NUM_ACC)) u_mux (
        .src   (ins.src),
        .regs  (st_q.regs),
        .accs  (st_q.accs),
        .pc    (st_q.pc),
        .cf    (st_q.cf),
        .zf    (st_q.zf),
        .value (src_val)
    );

    always_comb begin
        acc_cur = '0;
        for (int k = 0; k < NUM_ACC; k++) begin
            if (acc_we[k]) acc_cur = st_q.accs[k];
        end
    end

    xfer_alu u_alu (
        .op      (acc_op),
        .acc     (acc_cur),
        .operand (mov_val),
        .result  (alu_res),
        .carry   (alu_c),
        .zero    (alu_z),
        .arith   (alu_arith)
    );

    always_comb begin
        imm_val = st_q.pfx_v ? {st_q.pfx, ins.src} : {{PFX_W{1'b0}}, ins.src};
        mov_val = ins.fmt ? src_val : imm_val;
        if (ins.fmt)          jmp_tgt = mov_val[PC_W-1:0];
        else if (st_q.pfx_v)  jmp_tgt = imm_val[PC_W-1:0];
        else                  jmp_tgt = {st_q.pc[PC_W-1:SRC_W], ins.src};
    end

    always_comb begin
        st_d       = st_q;
        st_d.pc    = st_q.pc + PC_W'(1);
        st_d.pfx_v = 1'b0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (reg_we[i]) st_d.regs[i] = mov_val;
        end
        for (int k = 0; k < NUM_ACC; k++) begin
            if (acc_we[k]) st_d.accs[k] = alu_res;
        end
        if ((|acc_we) && alu_arith) begin
            st_d.cf = alu_c;
            st_d.zf = alu_z;
        end
        if (stat_we) begin
            st_d.cf = mov_val[0];
            st_d.zf = mov_val[1];
        end
        if (pfx_we) begin
            st_d.pfx   = mov_val[SRC_W-1:0];
            st_d.pfx_v = 1'b1;
        end
        if (pc_we) st_d.pc = jmp_tgt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign imem_addr = rst_n ? st_d.pc : '0;
    assign pc_o      = st_q.pc;
    assign acc_o     = st_q.accs;
    assign reg_o     = st_q.regs;
    assign flags_o   = {st_q.zf, st_q.cf};
endmodule

// File: rtl/xfer_core_chk.sv
module xfer_core_chk #(
    parameter int PC_W    = 16,
    parameter int NUM_REG = 4,
    parameter int NUM_ACC = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PC_W-1:0]         imem_addr,
    input logic [15:0]             imem_rdata,
    input logic [PC_W-1:0]         pc_o,
    input logic [NUM_ACC*16-1:0]   acc_o,
    input logic [NUM_REG*16-1:0]   reg_o,
    input logic [1:0]              flags_o
);
    logic [6:0] dst;
    logic       dst_mapped, dst_flagging;

    assign dst = imem_rdata[14:8];

    always_comb begin
        dst_mapped   = (dst == 7'h20) || (dst == 7'h21) || (dst == 7'h22) ||
                       (int'(dst) < NUM_REG);
        dst_flagging = (dst == 7'h22);
        for (int k = 0; k < NUM_ACC; k++) begin
            for (int op = 0; op < 3; op++) begin
                if (int'(dst) == 16 + 4 * k + op) begin
                    dst_mapped = 1'b1;
                    if (op != 0) dst_flagging = 1'b1;
                end
            end
        end
    end

    a_r1_addr_zero_in_reset: assert property (@(posedge clk)
        !rst_n |-> imem_addr == '0);

    a_r8_fetch_matches_pc: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc_o == $past(imem_addr));

    a_r8_pc_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dst != 7'h20) |=> pc_o == $past(pc_o) + PC_W'(1));

    a_r11_unmapped_dst_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_mapped |=> $stable(acc_o) && $stable(reg_o) && $stable(flags_o));

    a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_flagging |=> $stable(flags_o));
endmodule

bind xfer_core xfer_core_chk #(.PC_W(PC_W), .NUM_REG(NUM_REG), .NUM_ACC(NUM_ACC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .pc_o       (pc_o),
    .acc_o      (acc_o),
    .reg_o      (reg_o),
    .flags_o    (flags_o)
);

// File: tb/xfer_core_bench.sv
`timescale 1ns/1ps
module xfer_core_bench;
    localparam int PC_W = 16, NUM_REG = 4, NUM_ACC = 2;
    localparam logic [15:0] NOP = 16'h7F00;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [PC_W-1:0]        imem_addr;
    logic [15:0]            imem_rdata;
    logic [PC_W-1:0]        pc_o;
    logic [NUM_ACC*16-1:0]  acc_o;
    logic [NUM_REG*16-1:0]  reg_o;
    logic [1:0]             flags_o;
    logic [15:0]            mem [1024];
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) imem_rdata <= mem[imem_addr[9:0]];

    xfer_core #(.PC_W(PC_W), .NUM_REG(NUM_REG), .NUM_ACC(NUM_ACC)) u_xfer_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .pc_o(pc_o), .acc_o(acc_o), .reg_o(reg_o), .flags_o(flags_o)
    );

    function automatic logic [15:0] enc(input logic f, input logic [6:0] d, input logic [7:0] s);
        return {f, d, s};
    endfunction

    function automatic logic [15:0] rg(input int i);
        return reg_o[i*16 +: 16];
    endfunction

    function automatic logic [15:0] ac(input int k);
        return acc_o[k*16 +: 16];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_begin();
        rst_n = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 1024; a++) mem[a] = NOP;
    endtask

    task automatic release_run(input int cycles);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic t_moves();
        load_begin();
        mem[0] = enc(0, 7'h00, 8'hA5);
        mem[1] = enc(0, 7'h01, 8'h3C);
        mem[2] = enc(1, 7'h02, 8'h00);
        mem[3] = enc(1, 7'h10, 8'h01);
        mem[4] = enc(0, 7'h03, 8'h77);
        mem[5] = enc(1, 7'h03, 8'h55);
        release_run(5);
        chk("R3 immediate zero-extended", rg(3), 32'h0077);
        @(negedge clk);
        chk("R3 immediate into R0", rg(0), 32'h00A5);
        chk("R2 field split immediate R1", rg(1), 32'h003C);
        chk("R4 move R0 to R2", rg(2), 32'h00A5);
        chk("R6 acc load via move", ac(0), 32'h003C);
        chk("R5 unmapped source reads zero", rg(3), 32'h0000);
        chk("R8 pc after six cycles", pc_o, 32'h0006);
        chk("R7 load leaves flags", flags_o, 32'h0);
    endtask

    task automatic t_arith();
        load_begin();
        mem[0] = enc(0, 7'h21, 8'hFF);
        mem[1] = enc(0, 7'h10, 8'hF0);
        mem[2] = enc(0, 7'h11, 8'h20);
        mem[3] = enc(0, 7'h14, 8'h05);
        mem[4] = enc(0, 7'h16, 8'h05);
        mem[5] = enc(0, 7'h16, 8'h01);
        mem[6] = enc(1, 7'h00, 8'h22);
        mem[7] = enc(0, 7'h7F, 8'h12);
        mem[8] = enc(1, 7'h11, 8'h11);
        release_run(2);
        chk("R10 prefix forms 16-bit immediate", ac(0), 32'hFFF0);
        @(negedge clk);
        chk("R6 add alias result", ac(0), 32'h0010);
        chk("R7 add carry-out", flags_o, 32'h1);
        repeat (2) @(negedge clk);
        chk("R6 sub alias result", ac(1), 32'h0000);
        chk("R7 sub zero flag", flags_o, 32'h2);
        @(negedge clk);
        chk("R6 sub wraps", ac(1), 32'hFFFF);
        chk("R7 sub borrow", flags_o, 32'h1);
        @(negedge clk);
        chk("R4 status source", rg(0), 32'h0001);
        repeat (2) @(negedge clk);
        chk("R6 add from other accumulator", ac(0), 32'h000F);
        chk("R7 carry after move add", flags_o, 32'h1);
        chk("R8 pc after nine cycles", pc_o, 32'h0009);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #1;
        chk("R1 address zero in reset", imem_addr, 32'h0);
        for (int a = 0; a < 1024; a++) mem[a] = NOP;
        mem[0] = enc(0, 7'h20, 8'h40);
        repeat (2) @(negedge clk);
        chk("R1 pc cleared", pc_o, 32'h0);
        chk("R1 accumulators cleared", acc_o, 32'h0);
        chk("R1 registers cleared", reg_o[31:0], 32'h0);
        chk("R1 flags cleared", flags_o, 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R1 word at 0 executes first", imem_addr, 32'h0040);
        @(negedge clk);
        chk("R1 jump taken from address 0", pc_o, 32'h0040);
    endtask

    task automatic t_ignored();
        load_begin();
        mem[0] = enc(0, 7'h00, 8'h11);
        mem[1] = enc(0, 7'h10, 8'h22);
        mem[2] = enc(0, 7'h22, 8'h03);
        mem[3] = enc(0, 7'h13, 8'h99);
        mem[4] = enc(1, 7'h30, 8'h00);
        mem[5] = enc(0, 7'h7F, 8'hFF);
        mem[6] = enc(0, 7'h1B, 8'h01);
        release_run(3);
        chk("R7 status write sets flags", flags_o, 32'h3);
        repeat (4) @(negedge clk);
        chk("R11 acc unchanged", ac(0), 32'h0022);
        chk("R11 acc1 unchanged", ac(1), 32'h0000);
        chk("R11 reg unchanged", rg(0), 32'h0011);
        chk("R11 flags unchanged", flags_o, 32'h3);
        chk("R11 pc advanced", pc_o, 32'h0007);
    endtask

    task automatic t_jumps();
        load_begin();
        mem[0]      = enc(0, 7'h20, 8'h10);
        mem[16]     = enc(0, 7'h00, 8'h01);
        mem[17]     = enc(0, 7'h21, 8'h02);
        mem[18]     = enc(0, 7'h20, 8'h00);
        mem[512]    = enc(0, 7'h01, 8'h02);
        mem[513]    = enc(1, 7'h02, 8'h20);
        mem[514]    = enc(0, 7'h03, 8'h03);
        mem[515]    = enc(0, 7'h10, 8'h80);
        mem[516]    = enc(1, 7'h20, 8'h10);
        mem[128]    = enc(0, 7'h00, 8'h09);
        release_run(1);
        chk("R9 short jump one cycle", pc_o, 32'h0010);
        repeat (3) @(negedge clk);
        chk("R10 long jump lands in far page", pc_o, 32'h0200);
        chk("R9 target-page instruction ran", rg(0), 32'h0001);
        repeat (3) @(negedge clk);
        chk("R10 prefix consumed once", rg(1), 32'h0002);
        chk("R9 target executes next cycle", rg(2), 32'h0201);
        chk("R8 full rate after jump", rg(3), 32'h0003);
        repeat (3) @(negedge clk);
        chk("R9 format-1 jump full target", pc_o, 32'h0081);
        chk("R9 instruction at moved target", rg(0), 32'h0009);
    endtask

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = NOP;
        repeat (3) @(negedge clk);
        t_moves();
        t_arith();
        t_reset();
        t_ignored();
        t_jumps();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule